// File: doc/BRIEF.md
# Programmable Parallel I/O Strobe Controller

This block sits between a processor core and an asynchronous 16-bit parallel port that serves eight channels. The core hands it one read or one write at a time. Each direction of the port has its own mode. In active mode the block generates the data strobe, drives a 3-bit channel number, and either drives write data or samples read data on the shared bus. In passive mode an external device drives the strobe, and the block only latches or presents data on the rising edge of that strobe.

The core sends requests on a valid/ready stream: `req_valid` is held with its payload until `req_ready` is high at a rising clock edge. Back-pressure comes from the strobe timing. While an active strobe is high, `req_ready` stays low, and a request that waits in that window with a width code other than the minimum sets a sticky gap error. Read results come back as a one-cycle `rsp_valid` pulse. The response side takes no back-pressure, so the core must accept the pulse when it appears.

A control word written through `cfg_we` sets the two modes and the strobe width. The word is held back until no strobe is in progress, so a running access is never altered.

Top module: `pio_strobe_ctrl`

## Requirements
- R1: After reset both strobe outputs, both strobe enables, `bus_oe`, `chan_oe`, `rsp_valid` and `err_gap` are 0, and `req_ready` is 1. Both directions start in passive mode with width code 0.
- R2: Control word layout: bit 12 set makes the input direction active, bit 11 set makes the output direction active, bits 14:13 hold the width code, and writing bit 15 as 1 clears `err_gap`. A written word takes effect at the first clock edge after the write where no strobe is high and no request is accepted. `in_stb_oe` equals the applied bit 12 and `out_stb_oe` equals the applied bit 11.
- R3: An accepted active access raises its strobe in the cycle after acceptance and holds it high for exactly width code + 1 cycles. Reads use `in_stb_o` and writes use `out_stb_o`.
- R4: Between two active strobes there is always at least one low cycle. With width code 0 and a request held valid, the strobe alternates one high cycle and one low cycle.
- R5: `req_ready` is 0 in every cycle an active strobe is high. A request waiting in that window is accepted in the first low cycle after the strobe.
- R6: `err_gap` goes to 1 on the edge after any cycle in which `req_valid` is high while a strobe is high and the width code is not 0. It stays 1 until a control write with bit 15 set. It is never set when the width code is 0.
- R7: An active read samples `bus_i` at the clock edge that ends the strobe. It then raises `rsp_valid` for one cycle, in the first cycle after the strobe, with that sample on `rsp_data`.
- R8: On an active write, `bus_oe` is 1 and `bus_o` carries the request data in exactly the cycles `out_stb_o` is high.
- R9: `chan_o` shows the channel of the current or latest active access, and `chan_oe` is 1 only when both directions are active.
- R10: In passive input mode a rising edge on `in_stb_i`, seen through a two-flop synchronizer, latches `bus_i` into the input holding register. A core read then returns that value with `rsp_valid` in the cycle after acceptance.
- R11: In passive output mode a core write loads the output holding register. `bus_oe` rises three cycles after `out_stb_i` rises, with that value on `bus_o`, and falls three cycles after `out_stb_i` falls.
- R12: When one direction is active and the other passive, no request is accepted while the synchronized passive strobe is high. An active strobe therefore never starts while the opposite external strobe is seen as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at this edge when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 3 | Channel number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read result pulse |
| rsp_data | output | 16 | Read result |
| err_gap | output | 1 | Sticky early-request flag |
| in_stb_o | output | 1 | Input strobe, active mode |
| in_stb_oe | output | 1 | Input strobe pin drive enable |
| in_stb_i | input | 1 | External input strobe, passive mode |
| out_stb_o | output | 1 | Output strobe, active mode |
| out_stb_oe | output | 1 | Output strobe pin drive enable |
| out_stb_i | input | 1 | External output strobe, passive mode |
| chan_o | output | 3 | Channel select |
| chan_oe | output | 1 | Channel select drive enable |
| bus_i | input | 16 | Data bus sampled value |
| bus_o | output | 16 | Data bus driven value |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that external strobes obey the handshake. In mixed mode the external device keeps its strobe low while the block's own strobe runs. In passive mode `bus_i` holds still for the three cycles the synchronizer needs. The core also keeps the payload stable while `req_valid` waits. The stimulus respects all of this. It changes external strobes and the bus only on a falling-edge-offset schedule, raises an external strobe only while no active access is running, and keeps each request constant until the edge that accepts it. Within those limits the sweeps cover every width code against every channel in both directions.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int CFG_W       = 16;
  localparam int CLR_BIT     = 15;
  localparam int WID_HI      = 14;
  localparam int WID_LO      = 13;
  localparam int IN_ACT_BIT  = 12;
  localparam int OUT_ACT_BIT = 11;
  localparam int LEN_W       = WID_HI - WID_LO + 1;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_STROBE  = 2'd1,
    SEQ_RECOVER = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] width;
    logic             in_act;
    logic             out_act;
  } pio_cfg_t;
endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
#(
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          apply_ok_i,
  output pio_cfg_t      cfg_o,
  output logic          clr_req_o
);
  pio_cfg_t cfg_q, pend_q, wr_cfg;
  logic     pend_v_q;
  logic     unused_low_bits;

  assign unused_low_bits = ^wdata_i[OUT_ACT_BIT-1:0];

  always_comb begin
    wr_cfg.width   = wdata_i[WID_HI:WID_LO];
    wr_cfg.in_act  = wdata_i[IN_ACT_BIT];
    wr_cfg.out_act = wdata_i[OUT_ACT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (we_i) begin
      pend_q   <= wr_cfg;
      pend_v_q <= 1'b1;
    end else if (pend_v_q && apply_ok_i) begin
      cfg_q    <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign cfg_o     = cfg_q;
  assign clr_req_o = we_i && wdata_i[CLR_BIT];

  // R2: the applied word only moves on an edge that allowed it
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apply_ok_i) |-> $stable(cfg_q));
endmodule

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] level_o,
  output logic [LANES-1:0] rise_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2:0] sh_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], async_i[g]};
    end
    assign level_o[g] = sh_q[1];
    assign rise_o[g]  = sh_q[1] & ~sh_q[2];
  end
endmodule

// File: rtl/pio_active_seq.sv
module pio_active_seq
  import pio_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CHW = 3,
  parameter int LW  = LEN_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           start_write_i,
  input  logic [CHW-1:0] start_chan_i,
  input  logic [DW-1:0]  start_data_i,
  input  logic [LW-1:0]  start_len_i,
  input  logic [DW-1:0]  bus_i,
  output logic           free_o,
  output logic           strobe_o,
  output logic           write_o,
  output logic [CHW-1:0] chan_o,
  output logic [DW-1:0]  data_o,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o
);
  localparam int RUN_W = LW + 1;

  seq_state_e     state_q;
  logic [LW-1:0]  cnt_q, len_q;
  logic           write_q, rd_valid_q;
  logic [CHW-1:0] chan_q;
  logic [DW-1:0]  data_q, rd_data_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      write_q    <= 1'b0;
      chan_q     <= '0;
      data_q     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      case (state_q)
        SEQ_IDLE, SEQ_RECOVER: begin
          if (start_i) begin
            state_q <= SEQ_STROBE;
            cnt_q   <= start_len_i;
            len_q   <= start_len_i;
            write_q <= start_write_i;
            chan_q  <= start_chan_i;
            data_q  <= start_data_i;
          end else begin
            state_q <= SEQ_IDLE;
          end
        end
        SEQ_STROBE: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_RECOVER;
            if (!write_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= bus_i;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (strobe_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  assign free_o     = (state_q != SEQ_STROBE);
  assign strobe_o   = (state_q == SEQ_STROBE);
  assign write_o    = write_q;
  assign chan_o     = chan_q;
  assign data_o     = data_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R3: every strobe lasts width code + 1 cycles
  assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> run_q == ({1'b0, len_q} + {{LW{1'b0}}, 1'b1}));
  // R7: the end of a read strobe brings the response pulse
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o && !write_q) |-> rd_valid_o);
  // R5: a new access only starts from a non-strobe state
  assert_start_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> free_o);
endmodule

// File: rtl/pio_passive_port.sv
module pio_passive_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] bus_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          pres_rise_i,
  input  logic          pres_level_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] out_q_o,
  output logic          pres_o
);
  logic [DW-1:0] in_q, out_q;
  logic          pres_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      pres_q <= 1'b0;
    end else begin
      if (cap_i)  in_q  <= bus_i;
      if (load_i) out_q <= load_data_i;
      if (pres_rise_i)        pres_q <= 1'b1;
      else if (!pres_level_i) pres_q <= 1'b0;
    end
  end

  assign in_q_o  = in_q;
  assign out_q_o = out_q;
  assign pres_o  = pres_q;

  // R10: a synchronized rising edge stores the bus value
  assert_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> in_q_o == $past(bus_i));
endmodule

// File: rtl/pio_strobe_ctrl.sv
module pio_strobe_ctrl
  import pio_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CHW-1:0] req_chan,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data,
  output logic           err_gap,
  output logic           in_stb_o,
  output logic           in_stb_oe,
  input  logic           in_stb_i,
  output logic           out_stb_o,
  output logic           out_stb_oe,
  input  logic           out_stb_i,
  output logic [CHW-1:0] chan_o,
  output logic           chan_oe,
  input  logic [DW-1:0]  bus_i,
  output logic [DW-1:0]  bus_o,
  output logic           bus_oe
);
  localparam int LANE_IN  = 0;
  localparam int LANE_OUT = 1;

  pio_cfg_t      cfg_q;
  logic          clr_req, apply_ok;
  logic [1:0]    stb_lvl, stb_rise;
  logic          seq_free, seq_strobe, seq_write, act_rd_valid;
  logic [CHW-1:0] seq_chan;
  logic [DW-1:0] seq_data, act_rd_data, pas_in_q, pas_out_q;
  logic          pas_pres;
  logic          fire, act_start, pas_wr, pas_rd, conflict;
  logic          pas_rd_valid_q, err_q;
  logic [DW-1:0] pas_rd_data_q;

  // ---------------- control word ----------------
  pio_cfg_reg #(.CW(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .apply_ok_i(apply_ok), .cfg_o(cfg_q), .clr_req_o(clr_req)
  );

  // ---------------- external strobe synchronizers ----------------
  pio_edge_sync #(.LANES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({out_stb_i, in_stb_i}),
    .level_o(stb_lvl), .rise_o(stb_rise)
  );

  // ---------------- request acceptance ----------------
  always_comb begin
    conflict = (cfg_q.in_act && !cfg_q.out_act && stb_lvl[LANE_OUT]) ||
               (cfg_q.out_act && !cfg_q.in_act && stb_lvl[LANE_IN]);
    req_ready = seq_free && !conflict;
    fire      = req_valid && req_ready;
    act_start = fire && (req_write ? cfg_q.out_act : cfg_q.in_act);
    pas_wr    = fire && req_write && !cfg_q.out_act;
    pas_rd    = fire && !req_write && !cfg_q.in_act;
    apply_ok  = seq_free && !fire;
  end

  // ---------------- active strobe sequencer ----------------
  pio_active_seq #(.DW(DW), .CHW(CHW), .LW(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(act_start),
    .start_write_i(req_write), .start_chan_i(req_chan),
    .start_data_i(req_wdata), .start_len_i(cfg_q.width), .bus_i(bus_i),
    .free_o(seq_free), .strobe_o(seq_strobe), .write_o(seq_write),
    .chan_o(seq_chan), .data_o(seq_data),
    .rd_valid_o(act_rd_valid), .rd_data_o(act_rd_data)
  );

  // ---------------- passive holding registers ----------------
  pio_passive_port #(.DW(DW)) u_pas (
    .clk(clk), .rst_n(rst_n),
    .cap_i(stb_rise[LANE_IN] && !cfg_q.in_act), .bus_i(bus_i),
    .load_i(pas_wr), .load_data_i(req_wdata),
    .pres_rise_i(stb_rise[LANE_OUT] && !cfg_q.out_act),
    .pres_level_i(stb_lvl[LANE_OUT] && !cfg_q.out_act),
    .in_q_o(pas_in_q), .out_q_o(pas_out_q), .pres_o(pas_pres)
  );

  // ---------------- response and sticky error ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pas_rd_valid_q <= 1'b0;
      pas_rd_data_q  <= '0;
      err_q          <= 1'b0;
    end else begin
      pas_rd_valid_q <= pas_rd;
      if (pas_rd) pas_rd_data_q <= pas_in_q;
      if (req_valid && seq_strobe && (cfg_q.width != '0)) err_q <= 1'b1;
      else if (clr_req)                                   err_q <= 1'b0;
    end
  end

  // ---------------- pin drive ----------------
  assign rsp_valid  = act_rd_valid | pas_rd_valid_q;
  assign rsp_data   = act_rd_valid ? act_rd_data : pas_rd_data_q;
  assign err_gap    = err_q;
  assign in_stb_o   = seq_strobe && !seq_write;
  assign out_stb_o  = seq_strobe && seq_write;
  assign in_stb_oe  = cfg_q.in_act;
  assign out_stb_oe = cfg_q.out_act;
  assign chan_o     = seq_chan;
  assign chan_oe    = cfg_q.in_act && cfg_q.out_act;
  assign bus_oe     = (seq_strobe && seq_write) || (pas_pres && !cfg_q.out_act);
  assign bus_o      = (seq_strobe && seq_write) ? seq_data : pas_out_q;

  // R5: no acceptance while a strobe is out
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb_o || out_stb_o) |-> !req_ready);
  // R6: an early request with a wide strobe raises the flag
  assert_gap_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (in_stb_o || out_stb_o) && cfg_q.width != '0) |=> err_gap);
  // R6: the flag holds until cleared
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_gap && !clr_req) |=> err_gap);
  // R8: the bus is driven only by an output strobe or a passive presentation
  assert_bus_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (out_stb_o || !out_stb_oe));
  // R7: the two response sources never collide
  assert_rsp_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_rd_valid, pas_rd_valid_q}));
  // R12: an active strobe never starts against a seen external strobe
  assert_mixed_in_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_stb_o) && !out_stb_oe) |-> !$past(stb_lvl[LANE_OUT]));
  assert_mixed_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_stb_o) && !in_stb_oe) |-> !$past(stb_lvl[LANE_IN]));
endmodule

// File: tb/pio_strobe_ctrl_tb_top.sv
module pio_strobe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        req_valid, req_ready, req_write;
  logic [2:0]  req_chan;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        err_gap;
  logic        in_stb_o, in_stb_oe, in_stb_i;
  logic        out_stb_o, out_stb_oe, out_stb_i;
  logic [2:0]  chan_o;
  logic        chan_oe;
  logic [15:0] bus_in, bus_o;
  logic        bus_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_chan(req_chan), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_gap(err_gap),
    .in_stb_o(in_stb_o), .in_stb_oe(in_stb_oe), .in_stb_i(in_stb_i),
    .out_stb_o(out_stb_o), .out_stb_oe(out_stb_oe), .out_stb_i(out_stb_i),
    .chan_o(chan_o), .chan_oe(chan_oe),
    .bus_i(bus_in), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input logic [1:0] w, input logic ia,
                                         input logic oa, input logic clr);
    return {clr, w, ia, oa, 11'd0};
  endfunction

  task automatic set_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  // One active access with width code w; checks R3, R5, R7, R8, R9
  task automatic do_active(input int w, input bit wr, input int ch);
    logic [15:0] wd, pat;
    wd  = 16'hA000 + 16'(w * 256 + ch * 16 + int'(wr));
    pat = 16'h5A00 ^ 16'(w * 37 + ch * 5);
    bus_in = ~pat;
    req_valid = 1'b1; req_write = wr; req_chan = 3'(ch); req_wdata = wd;
    tick();
    req_valid = 1'b0;
    for (int i = 0; i <= w; i++) begin
      chk((wr ? out_stb_o : in_stb_o) == 1'b1, "R3 strobe high", 
          {31'd0, wr ? out_stb_o : in_stb_o}, 1);
      chk((wr ? in_stb_o : out_stb_o) == 1'b0, "R3 other strobe low",
          {31'd0, wr ? in_stb_o : out_stb_o}, 0);
      chk(req_ready == 1'b0, "R5 stall during strobe", {31'd0, req_ready}, 0);
      chk(bus_oe == wr, "R8 bus enable during strobe", {31'd0, bus_oe}, {31'd0, wr});
      if (wr) chk(bus_o == wd, "R8 write data", {16'd0, bus_o}, {16'd0, wd});
      chk(chan_o == 3'(ch) && chan_oe, "R9 channel", {28'd0, chan_oe, chan_o},
          {28'd1, 3'(ch)});
      if (i == w) bus_in = pat;
      tick();
    end
    chk(!in_stb_o && !out_stb_o, "R3 strobe ends", {30'd0, in_stb_o, out_stb_o}, 0);
    chk(bus_oe == 1'b0, "R8 bus released", {31'd0, bus_oe}, 0);
    chk(req_ready == 1'b1, "R4 low cycle accepts", {31'd0, req_ready}, 1);
    chk(rsp_valid == !wr, "R7 response pulse", {31'd0, rsp_valid}, {31'd0, !wr});
    if (!wr) chk(rsp_data == pat, "R7 captured at strobe end", {16'd0, rsp_data},
                 {16'd0, pat});
    tick();
    chk(rsp_valid == 1'b0, "R7 single pulse", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
    req_write = 1'b0; req_chan = '0; req_wdata = '0;
    in_stb_i = 1'b0; out_stb_i = 1'b0; bus_in = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk({in_stb_o, out_stb_o, in_stb_oe, out_stb_oe, bus_oe, chan_oe, rsp_valid,
         err_gap} == 8'd0, "R1 outputs idle",
        {24'd0, in_stb_o, out_stb_o, in_stb_oe, out_stb_oe, bus_oe, chan_oe,
         rsp_valid, err_gap}, 0);
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 1);

    // R2 mode bits reach the enables
    set_cfg(mk_cfg(2'd0, 1'b1, 1'b0, 1'b0));
    chk(in_stb_oe && !out_stb_oe, "R2 input active only",
        {30'd0, in_stb_oe, out_stb_oe}, 2);
    set_cfg(mk_cfg(2'd0, 1'b0, 1'b1, 1'b0));
    chk(!in_stb_oe && out_stb_oe && !chan_oe, "R2 R9 output active only",
        {29'd0, in_stb_oe, out_stb_oe, chan_oe}, 2);

    // Sweep: all widths, both directions, all channels
    for (int w = 0; w < 4; w++) begin
      set_cfg(mk_cfg(2'(w), 1'b1, 1'b1, 1'b0));
      chk(chan_oe == 1'b1, "R9 both active enables channel", {31'd0, chan_oe}, 1);
      for (int ch = 0; ch < 8; ch++)
        for (int wr = 0; wr < 2; wr++)
          do_active(w, wr[0], ch);
      chk(err_gap == 1'b0, "R6 no flag with gaps respected", {31'd0, err_gap}, 0);
    end

    // R4 back-to-back at width code 0
    set_cfg(mk_cfg(2'd0, 1'b1, 1'b1, 1'b0));
    req_valid = 1'b1; req_write = 1'b1; req_chan = 3'd2; req_wdata = 16'h1111;
    tick();
    chk(out_stb_o == 1'b1, "R4 first high", {31'd0, out_stb_o}, 1);
    tick();
    chk(out_stb_o == 1'b0 && req_ready, "R4 one low cycle", {30'd0, out_stb_o, req_ready}, 1);
    tick();
    chk(out_stb_o == 1'b1, "R4 second high", {31'd0, out_stb_o}, 1);
    req_valid = 1'b0;
    tick();
    chk(out_stb_o == 1'b0, "R4 second low", {31'd0, out_stb_o}, 0);
    chk(err_gap == 1'b0, "R6 no flag at width code 0", {31'd0, err_gap}, 0);
    repeat (2) tick();

    // R6 early request at width code 2 (three-cycle strobe)
    set_cfg(mk_cfg(2'd2, 1'b1, 1'b1, 1'b0));
    req_valid = 1'b1; req_write = 1'b0; req_chan = 3'd5;
    tick();
    chk(err_gap == 1'b0, "R6 flag not yet", {31'd0, err_gap}, 0);
    tick();
    chk(err_gap == 1'b1, "R6 flag set", {31'd0, err_gap}, 1);
    tick();
    chk(in_stb_o == 1'b1 && !req_ready, "R5 still stalled", {30'd0, in_stb_o, req_ready}, 2);
    tick();
    chk(in_stb_o == 1'b0 && req_ready, "R5 accepted in low cycle", {30'd0, in_stb_o, req_ready}, 1);
    tick();
    chk(in_stb_o == 1'b1, "R5 held request served", {31'd0, in_stb_o}, 1);
    req_valid = 1'b0;
    repeat (5) tick();
    chk(err_gap == 1'b1, "R6 flag sticky", {31'd0, err_gap}, 1);
    cfg_we = 1'b1; cfg_wdata = mk_cfg(2'd2, 1'b1, 1'b1, 1'b1);
    tick();
    cfg_we = 1'b0;
    chk(err_gap == 1'b0, "R6 flag cleared", {31'd0, err_gap}, 0);
    tick();

    // R2 deferred apply during a four-cycle strobe
    set_cfg(mk_cfg(2'd3, 1'b1, 1'b1, 1'b0));
    req_valid = 1'b1; req_write = 1'b0; req_chan = 3'd1;
    tick();
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_wdata = mk_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    tick();
    cfg_we = 1'b0;
    chk(in_stb_o && in_stb_oe, "R2 no change mid strobe", {30'd0, in_stb_o, in_stb_oe}, 3);
    repeat (2) tick();
    chk(in_stb_o && in_stb_oe, "R2 R3 strobe keeps old width", {30'd0, in_stb_o, in_stb_oe}, 3);
    tick();
    chk(!in_stb_o && in_stb_oe, "R2 not applied in strobe edge", {30'd0, in_stb_o, in_stb_oe}, 1);
    tick();
    chk(!in_stb_oe && !chan_oe, "R2 applied after strobe", {30'd0, in_stb_oe, chan_oe}, 0);

    // R10 passive input capture and read-back
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = 16'hBE00 + 16'(k * 17);
      bus_in = v; in_stb_i = 1'b1;
      repeat (3) tick();
      in_stb_i = 1'b0; bus_in = 16'h0000;
      repeat (3) tick();
      req_valid = 1'b1; req_write = 1'b0;
      tick();
      req_valid = 1'b0;
      chk(rsp_valid && rsp_data == v, "R10 passive read value",
          {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, v});
      chk(in_stb_o == 1'b0, "R10 no active strobe", {31'd0, in_stb_o}, 0);
      tick();
    end

    // R11 passive output presentation
    for (int k = 0; k < 3; k++) begin
      logic [15:0] d;
      d = 16'h1357 ^ 16'(k * 4099);
      req_valid = 1'b1; req_write = 1'b1; req_wdata = d;
      tick();
      req_valid = 1'b0;
      chk(bus_oe == 1'b0, "R11 idle bus", {31'd0, bus_oe}, 0);
      out_stb_i = 1'b1;
      repeat (2) tick();
      chk(bus_oe == 1'b0, "R11 not before sync", {31'd0, bus_oe}, 0);
      tick();
      chk(bus_oe && bus_o == d, "R11 presented", {15'd0, bus_oe, bus_o}, {15'd0, 1'b1, d});
      out_stb_i = 1'b0;
      repeat (2) tick();
      chk(bus_oe == 1'b1, "R11 held until sync low", {31'd0, bus_oe}, 1);
      tick();
      chk(bus_oe == 1'b0, "R11 released", {31'd0, bus_oe}, 0);
    end

    // R12 mixed mode: input active, output passive
    set_cfg(mk_cfg(2'd0, 1'b1, 1'b0, 1'b0));
    chk(chan_oe == 1'b0, "R9 mixed has no channel drive", {31'd0, chan_oe}, 0);
    out_stb_i = 1'b1;
    repeat (2) tick();
    req_valid = 1'b1; req_write = 1'b0; req_chan = 3'd3;
    #1;
    chk(req_ready == 1'b0, "R12 blocked by external strobe", {31'd0, req_ready}, 0);
    tick();
    chk(in_stb_o == 1'b0, "R12 no strobe started", {31'd0, in_stb_o}, 0);
    out_stb_i = 1'b0;
    repeat (2) tick();
    chk(req_ready == 1'b1, "R12 released", {31'd0, req_ready}, 1);
    tick();
    req_valid = 1'b0;
    chk(in_stb_o == 1'b1, "R12 access runs after release", {31'd0, in_stb_o}, 1);
    repeat (3) tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule